// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address sequence for one read or write burst of a synchronous memory. A start strobe captures a starting column, a length code and an ordering type. From the next cycle on, the block presents one column address per cycle with a valid flag, and it raises a last flag on the final beat. The controller that issues commands uses these addresses to step the data path through the burst.

Fixed bursts of 2, 4 or 8 beats stay inside an aligned block whose size is the burst length. In that block, only the low address bits move and the upper bits are held. Two orderings are available. Sequential order counts upward from the start offset and wraps back to the bottom of the block. Interleaved order takes the start offset XOR the beat number. A full-page burst steps the column upward by one every cycle, wraps at the top of the column range, and runs until a terminate input ends it. Full page supports only sequential order. If interleaved order is requested with full page, the block raises an error flag for that burst and uses sequential order.

A sequencing state machine has three states. In ST_IDLE no burst runs. In ST_FIXED a 2, 4 or 8 beat burst runs. In ST_PAGE a full-page burst runs. The transitions are as follows:
- T_START: a start strobe in any state moves to ST_FIXED or ST_PAGE according to the length code.
- T_DONE: the final fixed beat moves from ST_FIXED to ST_IDLE.
- T_TERM: the terminate input moves from ST_PAGE to ST_IDLE.
- T_HOLD: with none of these events, the machine stays in ST_IDLE, or advances one beat in a running state.

T_START takes priority over T_DONE and T_TERM.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is active, and after reset until the first start strobe, `valid_o`, `last_o` and `err_o` are low.
- R2: For length codes 0, 1 and 2 (2, 4 and 8 beats), column bits from 3 upward equal the start column on every beat. Bits above bit 0 (length 2) and above bit 1 (length 4) also equal the start column.
- R3: In sequential order (`ilv_i`=0), beat k has the low offset (s+k) mod N. Here s is the start column mod N, and the block base stays fixed. For example, 4 beats from offset 2 give 2,3,0,1.
- R4: In interleaved order (`ilv_i`=1) with a fixed length, beat k has the low offset s XOR k. For example, 8 beats from offset 5 give 5,4,7,6,1,0,3,2.
- R5: With length code 3 (full page), beat k is (start + k) mod 2^COL_W. The burst continues until `term_i` is high.
- R6: With length code 3 and `ilv_i`=1, `err_o` is high on every beat of that burst, and the order is the same as R5.
- R7: `last_o` is high on beat N-1 of a fixed burst. In a full-page burst, it is high in the same cycle as `term_i`.
- R8: A strobe sampled at a clock edge puts beat 0 on the outputs in the following cycle. Each later edge advances one beat. A fixed burst presents exactly N beats, and `valid_o` is low after them unless a new strobe arrives.
- R9: A start strobe during a running burst ends that burst. Beat 0 of the new burst is shown in the next cycle.
- R10: `term_i` has no effect during a fixed burst or while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled at the rising edge |
| start_col_i | input | COL_W | Starting column |
| len_i | input | 2 | Length code: 0=2, 1=4, 2=8, 3=full page |
| ilv_i | input | 1 | 1 selects interleaved order |
| term_i | input | 1 | Ends a full-page burst |
| col_o | output | COL_W | Column address of the current beat (0 when idle) |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of the burst |
| err_o | output | 1 | Interleaved order was requested with full page |

## Verification
`col_o`, `valid_o` and `err_o` come from registers. They change one edge after the strobe or the advance that causes them. `last_o` in a full-page burst follows `term_i` in the same cycle, with no register in between. The bench drives inputs on the falling edge and samples all outputs shortly after it, one cycle behind the stimulus sampled at the previous rising edge. The reference model is updated on the rising edge from the same driven values that the design samples, so every comparison lines up with the cycle in which the result is due.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [1:0] {
        LEN_2    = 2'd0,
        LEN_4    = 2'd1,
        LEN_8    = 2'd2,
        LEN_PAGE = 2'd3
    } len_code_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/bcs_mask_dec.sv
// Turns a length code into the mask of column bits that move during the burst.
module bcs_mask_dec #(
    parameter int COL_W = 10
) (
    input  logic [1:0]       len_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o
);
    import bcs_pkg::*;

    assign page_o = (len_i == LEN_PAGE);

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i == 0) begin : g_always
            assign mask_o[i] = 1'b1;
        end else if (i < 3) begin : g_low
            assign mask_o[i] = page_o || (len_i >= 2'(i));
        end else begin : g_high
            assign mask_o[i] = page_o;
        end
    end

endmodule

// File: rtl/bcs_beat_ctr.sv
// Beat counter: cleared by a start, advanced once per running beat.
module bcs_beat_ctr #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             adv_i,
    input  logic [COL_W-1:0] mask_i,
    output logic [COL_W-1:0] beat_o,
    output logic             at_end_o
);
    logic [COL_W-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (clear_i) begin
            beat_q <= '0;
        end else if (adv_i) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign beat_o   = beat_q;
    assign at_end_o = (beat_q == mask_i);

endmodule

// File: rtl/bcs_addr_gen.sv
// Forms the column of one beat from the base column, beat number and block mask.
module bcs_addr_gen #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] seq_off;
    logic [COL_W-1:0] ilv_off;
    logic [COL_W-1:0] moving;

    always_comb begin
        seq_off = (base_i + beat_i) & mask_i;
        ilv_off = (base_i ^ beat_i) & mask_i;
        moving  = ilv_i ? ilv_off : seq_off;
        col_o   = (base_i & ~mask_i) | moving;
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       len_i,
    input  logic             ilv_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    import bcs_pkg::*;

    initial begin
        if (COL_W < 3) $error("COL_W must be at least 3");
    end

    seq_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;
    logic             err_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic [COL_W-1:0] beat;
    logic             at_end;
    logic             ctr_adv;
    logic [COL_W-1:0] gen_col;

    bcs_mask_dec #(.COL_W(COL_W)) u_mask (
        .len_i  (len_i),
        .mask_o (dec_mask),
        .page_o (dec_page)
    );

    bcs_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start_i),
        .adv_i    (ctr_adv),
        .mask_i   (mask_q),
        .beat_o   (beat),
        .at_end_o (at_end)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_addr (
        .base_i (base_q),
        .beat_i (beat),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .col_o  (gen_col)
    );

    // Next state: T_START has priority, then T_DONE / T_TERM, else T_HOLD.
    always_comb begin
        state_d = state_q;
        ctr_adv = 1'b0;
        if (start_i) begin
            state_d = dec_page ? ST_PAGE : ST_FIXED;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_FIXED: begin
                    if (at_end) state_d = ST_IDLE;
                    else        ctr_adv = 1'b1;
                end
                ST_PAGE: begin
                    if (term_i) state_d = ST_IDLE;
                    else        ctr_adv = 1'b1;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register and per-burst parameters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                base_q <= start_col_i;
                mask_q <= dec_mask;
                ilv_q  <= ilv_i && !dec_page;
                err_q  <= ilv_i && dec_page;
            end
        end
    end

    // Outputs.
    always_comb begin
        col_o   = '0;
        valid_o = 1'b0;
        last_o  = 1'b0;
        err_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                valid_o = 1'b0;
            end
            ST_FIXED: begin
                col_o   = gen_col;
                valid_o = 1'b1;
                last_o  = at_end;
            end
            ST_PAGE: begin
                col_o   = gen_col;
                valid_o = 1'b1;
                last_o  = term_i;
                err_o   = err_q;
            end
            default: begin
                valid_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [1:0]       len_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             err_o
);
    logic [1:0] cur_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cur_len <= 2'd0;
        else if (start_i) cur_len <= len_i;
    end

    // R1: quiet outputs while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!valid_o && !last_o && !err_o)
                else $error("reset outputs not quiet");
        end
    end

    p_fixed_high_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(start_i) && cur_len != 2'd3)
        |-> col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]));

    p_page_increment_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(start_i) && cur_len == 2'd3)
        |-> col_o == $past(col_o) + 1'b1);

    p_err_only_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (valid_o && cur_len == 2'd3));

    p_last_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    p_last_ends_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    p_restart_beat0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_i       (len_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .err_o       (err_o)
);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;
    localparam int COL_W = 10;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [1:0]       len_i = 2'd0;
    logic             ilv_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, err_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model state
    bit m_active = 1'b0;
    int m_base = 0, m_k = 0, m_n = 0;
    bit m_ilv = 1'b0, m_err = 1'b0;

    always #10 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_i(len_i), .ilv_i(ilv_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    function automatic int exp_col();
        int off, blk;
        if (m_n == 0) return (m_base + m_k) % PAGE;
        off = m_base % m_n;
        blk = m_base - off;
        if (m_ilv) return blk + (off ^ m_k);
        return blk + ((off + m_k) % m_n);
    endfunction

    task automatic fail(string tag, string what, int act, int expv);
        n_fail++;
        $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    endtask

    task automatic compare(string ctx);
        bit e_last;
        int ec;
        string ctag;
        n_vec++;
        e_last = m_active && (m_n != 0 ? (m_k == m_n - 1) : term_i);
        // R8 / R9 / R10: beat presence; R1 before the first start
        if (valid_o !== m_active) fail({ctx, " R8"}, "valid", int'(valid_o), int'(m_active));
        // R7: last flag
        if (last_o !== e_last) fail({ctx, " R7"}, "last", int'(last_o), int'(e_last));
        // R6: error flag
        if (err_o !== (m_active && m_err)) fail({ctx, " R6"}, "err", int'(err_o), int'(m_active && m_err));
        if (m_active) begin
            ec = exp_col();
            ctag = (m_n == 0) ? (m_err ? "R6" : "R5") : (m_ilv ? "R4" : "R3");
            if (int'(col_o) != ec) fail({ctx, " ", ctag}, "col", int'(col_o), ec);
            // R2: block bits held for fixed lengths
            if (m_n != 0 && (int'(col_o) / m_n) != (m_base / m_n))
                fail({ctx, " R2"}, "block", int'(col_o) / m_n, m_base / m_n);
        end
    endtask

    // one cycle: drive at falling edge, compare, then model advances at rising edge
    task automatic step(string ctx, bit s, int col, int len, bit ilv, bit term);
        @(negedge clk);
        start_i = s; start_col_i = COL_W'(col); len_i = 2'(len); ilv_i = ilv; term_i = term;
        #1;
        compare(ctx);
        @(posedge clk);
        if (!rst_n) begin
            m_active = 1'b0;
        end else if (s) begin
            m_active = 1'b1; m_base = col; m_k = 0;
            m_n = (len == 0) ? 2 : (len == 1) ? 4 : (len == 2) ? 8 : 0;
            m_ilv = ilv && m_n != 0;
            m_err = ilv && m_n == 0;
        end else if (m_active) begin
            if (m_n != 0 ? (m_k == m_n - 1) : term) m_active = 1'b0;
            else m_k++;
        end
    endtask

    task automatic burst(string ctx, int col, int len, bit ilv, int beats);
        step(ctx, 1'b1, col, len, ilv, 1'b0);
        for (int i = 0; i < beats; i++) step(ctx, 1'b0, 0, 0, 1'b0, 1'b0);
    endtask

    initial begin
        // R1: reset and idle
        for (int i = 0; i < 3; i++) step("R1 reset", 1'b0, 0, 0, 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) step("R1 idle", 1'b0, 0, 0, 1'b0, 1'b0);
        // R10: term while idle
        step("R10 idle term", 1'b0, 0, 0, 1'b0, 1'b1);
        // R2 R3 R4 R7 R8: every start offset, every fixed length, both orders
        for (int len = 0; len < 3; len++)
            for (int ilv = 0; ilv < 2; ilv++)
                for (int off = 0; off < 8; off++)
                    burst("fixed", 'h2A8 + off, len, ilv[0], 9);
        // R3 example 4 beats from 2; R4 example 8 beats from 5
        burst("R3 ex", 'h1F2, 1, 1'b0, 5);
        burst("R4 ex", 'h0C5, 2, 1'b1, 9);
        // R10: term during a fixed burst
        step("R10 fixed", 1'b1, 'h133, 2, 1'b0, 1'b0);
        for (int i = 0; i < 9; i++) step("R10 fixed", 1'b0, 0, 0, 1'b0, 1'b1);
        // R5: full page crossing the top of the range, then terminate
        step("R5 page", 1'b1, PAGE - 5, 3, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++) step("R5 page", 1'b0, 0, 0, 1'b0, 1'b0);
        step("R5 R7 term", 1'b0, 0, 0, 1'b0, 1'b1);
        for (int i = 0; i < 2; i++) step("R5 after", 1'b0, 0, 0, 1'b0, 1'b0);
        // R6: interleaved requested with full page
        step("R6 page ilv", 1'b1, 'h07D, 3, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) step("R6 page ilv", 1'b0, 0, 0, 1'b0, 1'b0);
        step("R6 term", 1'b0, 0, 0, 1'b0, 1'b1);
        step("R6 after", 1'b0, 0, 0, 1'b0, 1'b0);
        // R9: restart mid fixed burst, then mid page burst, start beats term
        step("R9 a", 1'b1, 'h010, 2, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step("R9 a", 1'b0, 0, 0, 1'b0, 1'b0);
        step("R9 b", 1'b1, 'h3FE, 3, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step("R9 b", 1'b0, 0, 0, 1'b0, 1'b0);
        step("R9 c", 1'b1, 'h123, 1, 1'b1, 1'b1);
        for (int i = 0; i < 2; i++) step("R9 c", 1'b0, 0, 0, 1'b0, 1'b0);
        step("R9 d", 1'b1, 'h2C7, 0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step("R9 d", 1'b0, 0, 0, 1'b0, 1'b0);
        // back-to-back: new start on the last beat
        step("R9 e", 1'b1, 'h055, 1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step("R9 e", 1'b0, 0, 0, 1'b0, 1'b0);
        burst("R9 e2", 'h066, 0, 1'b1, 3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule